// File: doc/BRIEF.md
# Table Block Move Engine

The block copies a contiguous run of 68-bit table entries from one place to another. The places may sit in the same search device or in two different ones. A host hands over one 64-bit parameter word on a valid/ready command port. The engine decodes it into a source device and address, a destination device and address, and an entry count. It rejects counts outside 4 to 256. For an accepted count it walks the run one entry at a time: it reads the source entry, waits for the returned data, and writes that data to the matching destination entry.

All three data-carrying ports use valid/ready. A request that is raised stays raised, with its fields unchanged, until ready is seen high at a clock edge. The read-data return has no ready: the engine always takes it, because it holds at most one read in flight. The engine adds no cycle of its own between a handshake and the next request. The host command port is back-pressured for the whole time the engine is busy. `busy`, `done` and `error` are plain status pins.

Top module: `blk_move_engine`

## Requirements
- R1: Source fields come from the parameter word: the read address base is bits [15:0] and the read device ID is bits [23:19]. Every read request carries that device ID.
- R2: Destination fields come from the parameter word: the write address base is bits [39:24] and the write device ID is bits [47:43]. Every write request carries that device ID.
- R3: The entry count is bits [56:48]. An accepted move issues exactly that many read handshakes and that many write handshakes.
- R4: A count below 4 raises `error` for exactly one cycle, in the cycle after acceptance, and no read or write request is raised.
- R5: A count above 256 is treated the same as in R4.
- R6: Entry i (i = 0 .. count-1) is read from source base + i and then written to destination base + i. Addresses wrap modulo 2^16. Read i+1 is never requested before write i completes, and read and write requests are never raised together.
- R7: The data of write i equals the read-return data that answered read i.
- R8: `done` is high for exactly one cycle, in the cycle after the last write handshake. `done` and `error` are never high together.
- R9: `busy` rises in the cycle after acceptance and falls in the cycle after `done` or `error`. `cmd_ready` equals not-`busy`, so commands offered while busy are refused.
- R10: While a read or write request is held off by a low ready, its valid, device ID, address and data stay unchanged.
- R11: After reset, `busy`, `done`, `error`, `rd_req_valid` and `wr_valid` are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Parameter word offered |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_param | input | 64 | Move parameter word |
| rd_req_valid | output | 1 | Read request raised |
| rd_req_ready | input | 1 | Memory takes the read request |
| rd_req_dev | output | 5 | Source device ID |
| rd_req_addr | output | 16 | Source entry address |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | 68 | Returned entry |
| wr_valid | output | 1 | Write request raised |
| wr_ready | input | 1 | Memory takes the write request |
| wr_dev | output | 5 | Destination device ID |
| wr_addr | output | 16 | Destination entry address |
| wr_data | output | 68 | Entry to write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse after a completed move |
| error | output | 1 | One-cycle pulse for a rejected count |

## Verification
A wrong entry counter shows at the next request handshake. The address on that handshake lands off base + i, or the move ends with a write count other than the programmed one. Both show within one entry's turn. A wrong sequencer state shows as overlapping read and write requests, a missing or doubled `done`, or `cmd_ready` disagreeing with `busy` in the same cycle. A wrong length check shows one cycle after acceptance, as an `error` pulse on a legal count or as a read request on an illegal one. Data captured in the wrong cycle shows in the very next write as a payload that does not match the address read.

// File: rtl/blk_move_pkg.sv
package blk_move_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WAIT = 3'd2,
    ST_WR   = 3'd3,
    ST_DONE = 3'd4,
    ST_ERR  = 3'd5
  } mv_state_e;
endpackage

// File: rtl/blk_move_decode.sv
module blk_move_decode #(
  parameter int PARAM_W = 64,
  parameter int ADDR_W  = 16,
  parameter int DEV_W   = 5,
  parameter int LEN_W   = 9,
  parameter int MIN_LEN = 4,
  parameter int MAX_LEN = 256
) (
  input  logic [PARAM_W-1:0] param,
  output logic [DEV_W-1:0]   src_dev,
  output logic [ADDR_W-1:0]  src_addr,
  output logic [DEV_W-1:0]   dst_dev,
  output logic [ADDR_W-1:0]  dst_addr,
  output logic [LEN_W-1:0]   len,
  output logic               len_ok
);
  localparam int SRC_ADDR_LSB = 0;
  localparam int SRC_DEV_LSB  = 19;
  localparam int DST_ADDR_LSB = 24;
  localparam int DST_DEV_LSB  = 43;
  localparam int LEN_LSB      = 48;

  always_comb begin
    src_addr = param[SRC_ADDR_LSB +: ADDR_W];
    src_dev  = param[SRC_DEV_LSB  +: DEV_W];
    dst_addr = param[DST_ADDR_LSB +: ADDR_W];
    dst_dev  = param[DST_DEV_LSB  +: DEV_W];
    len      = param[LEN_LSB      +: LEN_W];
    len_ok   = (int'(len) >= MIN_LEN) && (int'(len) <= MAX_LEN);
  end
endmodule

// File: rtl/blk_move_ctrl.sv
module blk_move_ctrl
  import blk_move_pkg::*;
#(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             len_ok,
  input  logic [LEN_W-1:0] len_q,
  input  logic             rd_req_ready,
  input  logic             rd_rsp_valid,
  input  logic             wr_ready,
  output logic             cmd_ready,
  output logic             cmd_fire,
  output logic             rd_req_valid,
  output logic             wr_valid,
  output logic             capture,
  output logic [LEN_W-1:0] idx,
  output logic             busy,
  output logic             done,
  output logic             error
);
  mv_state_e state, state_n;
  logic      last;

  assign last = (idx == len_q - LEN_W'(1));

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE: if (cmd_valid) state_n = len_ok ? ST_RD : ST_ERR;
      ST_RD:   if (rd_req_ready) state_n = ST_WAIT;
      ST_WAIT: if (rd_rsp_valid) state_n = ST_WR;
      ST_WR:   if (wr_ready) state_n = last ? ST_DONE : ST_RD;
      ST_DONE: state_n = ST_IDLE;
      ST_ERR:  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      state <= state_n;
      if (cmd_fire) idx <= '0;
      else if (wr_valid && wr_ready) idx <= idx + LEN_W'(1);
    end
  end

  assign cmd_ready    = (state == ST_IDLE);
  assign cmd_fire     = cmd_ready && cmd_valid;
  assign rd_req_valid = (state == ST_RD);
  assign wr_valid     = (state == ST_WR);
  assign capture      = (state == ST_WAIT) && rd_rsp_valid;
  assign busy         = (state != ST_IDLE);
  assign done         = (state == ST_DONE);
  assign error        = (state == ST_ERR);

  // R4
  bad_len_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && !len_ok) |=> (error && !rd_req_valid));
  // R5
  good_len_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && len_ok) |=> (rd_req_valid && !error));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R8
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
endmodule

// File: rtl/blk_move_path.sv
module blk_move_path #(
  parameter int ADDR_W = 16,
  parameter int DEV_W  = 5,
  parameter int LEN_W  = 9,
  parameter int DATA_W = 68
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DEV_W-1:0]  src_dev_in,
  input  logic [ADDR_W-1:0] src_addr_in,
  input  logic [DEV_W-1:0]  dst_dev_in,
  input  logic [ADDR_W-1:0] dst_addr_in,
  input  logic [LEN_W-1:0]  len_in,
  input  logic [LEN_W-1:0]  idx,
  input  logic              capture,
  input  logic [DATA_W-1:0] rsp_data,
  output logic [LEN_W-1:0]  len_q,
  output logic [DEV_W-1:0]  rd_dev,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DEV_W-1:0]  wr_dev,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic [ADDR_W-1:0] src_base, dst_base;
  logic [ADDR_W-1:0] offset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_base <= '0;
      dst_base <= '0;
      rd_dev   <= '0;
      wr_dev   <= '0;
      len_q    <= '0;
      wr_data  <= '0;
    end else begin
      if (load) begin
        src_base <= src_addr_in;
        dst_base <= dst_addr_in;
        rd_dev   <= src_dev_in;
        wr_dev   <= dst_dev_in;
        len_q    <= len_in;
      end
      if (capture) wr_data <= rsp_data;
    end
  end

  generate
    if (LEN_W >= ADDR_W) begin : g_trunc
      assign offset = idx[ADDR_W-1:0];
    end else begin : g_ext
      assign offset = {{(ADDR_W-LEN_W){1'b0}}, idx};
    end
  endgenerate

  assign rd_addr = src_base + offset;
  assign wr_addr = dst_base + offset;
endmodule

// File: rtl/blk_move_engine.sv
module blk_move_engine #(
  parameter int PARAM_W = 64,
  parameter int ADDR_W  = 16,
  parameter int DEV_W   = 5,
  parameter int LEN_W   = 9,
  parameter int DATA_W  = 68,
  parameter int MIN_LEN = 4,
  parameter int MAX_LEN = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [PARAM_W-1:0] cmd_param,
  output logic               rd_req_valid,
  input  logic               rd_req_ready,
  output logic [DEV_W-1:0]   rd_req_dev,
  output logic [ADDR_W-1:0]  rd_req_addr,
  input  logic               rd_rsp_valid,
  input  logic [DATA_W-1:0]  rd_rsp_data,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [DEV_W-1:0]   wr_dev,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0]  wr_data,
  output logic               busy,
  output logic               done,
  output logic               error
);
  logic [DEV_W-1:0]  d_src_dev, d_dst_dev;
  logic [ADDR_W-1:0] d_src_addr, d_dst_addr;
  logic [LEN_W-1:0]  d_len, len_q, idx;
  logic              len_ok, cmd_fire, capture;

  blk_move_decode #(
    .PARAM_W(PARAM_W), .ADDR_W(ADDR_W), .DEV_W(DEV_W), .LEN_W(LEN_W),
    .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
  ) u_dec (
    .param(cmd_param), .src_dev(d_src_dev), .src_addr(d_src_addr),
    .dst_dev(d_dst_dev), .dst_addr(d_dst_addr), .len(d_len), .len_ok(len_ok)
  );

  blk_move_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .len_ok(len_ok),
    .len_q(len_q), .rd_req_ready(rd_req_ready), .rd_rsp_valid(rd_rsp_valid),
    .wr_ready(wr_ready), .cmd_ready(cmd_ready), .cmd_fire(cmd_fire),
    .rd_req_valid(rd_req_valid), .wr_valid(wr_valid), .capture(capture),
    .idx(idx), .busy(busy), .done(done), .error(error)
  );

  blk_move_path #(
    .ADDR_W(ADDR_W), .DEV_W(DEV_W), .LEN_W(LEN_W), .DATA_W(DATA_W)
  ) u_path (
    .clk(clk), .rst_n(rst_n), .load(cmd_fire),
    .src_dev_in(d_src_dev), .src_addr_in(d_src_addr),
    .dst_dev_in(d_dst_dev), .dst_addr_in(d_dst_addr), .len_in(d_len),
    .idx(idx), .capture(capture), .rsp_data(rd_rsp_data), .len_q(len_q),
    .rd_dev(rd_req_dev), .rd_addr(rd_req_addr), .wr_dev(wr_dev),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=>
      (rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_dev)));
  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=>
      (wr_valid && $stable(wr_addr) && $stable(wr_dev) && $stable(wr_data)));
  // R6
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req_valid, wr_valid, done, error}));
  // R6
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready) |=> !rd_req_valid);
endmodule

// File: tb/tb_blk_move_engine.sv
module tb_blk_move_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [63:0] cmd_param = '0;
  logic        rd_req_valid, rd_req_ready;
  logic [4:0]  rd_req_dev;
  logic [15:0] rd_req_addr;
  logic        rd_rsp_valid;
  logic [67:0] rd_rsp_data;
  logic        wr_valid, wr_ready;
  logic [4:0]  wr_dev;
  logic [15:0] wr_addr;
  logic [67:0] wr_data;
  logic        busy, done, error;

  int total = 0, bad = 0, cycles = 0;
  int rd_idx = 0, wr_idx = 0;
  logic [4:0]  e_sdev = '0, e_ddev = '0;
  logic [15:0] e_src = '0, e_dst = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic        stall_on = 1'b0;

  always #5 clk = ~clk;

  blk_move_engine dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_param(cmd_param), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_dev(rd_req_dev),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_dev(wr_dev), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .error(error)
  );

  function automatic logic [67:0] entry(input logic [4:0] dv, input logic [15:0] a);
    return {8'hC3, dv, a, ~a, a ^ 16'h1234, 7'h55};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [67:0] act,
                     input logic [67:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: ready pattern and one-cycle read return
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_req_ready <= 1'b0;
      wr_ready     <= 1'b0;
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= '0;
    end else begin
      lfsr         <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rd_req_ready <= stall_on ? lfsr[0] : 1'b1;
      wr_ready     <= stall_on ? lfsr[3] : 1'b1;
      rd_rsp_valid <= rd_req_valid && rd_req_ready;
      rd_rsp_data  <= entry(rd_req_dev, rd_req_addr);
    end
  end

  // port monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      // R9
      chk(cmd_ready == !busy, "R9 ready/busy", 68'(cmd_ready), 68'(!busy));
      if (rd_req_valid && rd_req_ready) begin
        chk(rd_req_addr == e_src + 16'(rd_idx), "R6 read addr",
            68'(rd_req_addr), 68'(e_src + 16'(rd_idx)));
        chk(rd_req_dev == e_sdev, "R1 read dev", 68'(rd_req_dev), 68'(e_sdev));
        chk(rd_idx == wr_idx, "R6 read order", 68'(rd_idx), 68'(wr_idx));
        rd_idx++;
      end
      if (wr_valid && wr_ready) begin
        chk(wr_addr == e_dst + 16'(wr_idx), "R2 write addr",
            68'(wr_addr), 68'(e_dst + 16'(wr_idx)));
        chk(wr_dev == e_ddev, "R2 write dev", 68'(wr_dev), 68'(e_ddev));
        chk(wr_data == entry(e_sdev, e_src + 16'(wr_idx)), "R7 write data",
            wr_data, entry(e_sdev, e_src + 16'(wr_idx)));
        wr_idx++;
      end
    end
  end

  task automatic run_move(input logic [4:0] sd, input logic [15:0] sa,
                          input logic [4:0] dd, input logic [15:0] da,
                          input int len);
    bit expect_err;
    expect_err = (len < 4) || (len > 256);
    @(negedge clk);
    e_sdev = sd; e_src = sa; e_ddev = dd; e_dst = da;
    rd_idx = 0; wr_idx = 0;
    cmd_param = {7'h0, 9'(len), 5'(dd), 3'b0, da, 5'(sd), 3'b0, sa};
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    // R9 busy in cycle after acceptance
    chk(busy == 1'b1, "R9 busy after accept", 68'(busy), 68'(1));
    if (expect_err) begin
      // R4 R5
      chk(error == 1'b1, "R4/R5 error pulse", 68'(error), 68'(1));
      @(negedge clk);
      chk(error == 1'b0 && busy == 1'b0, "R4/R5 single error cycle",
          68'({error, busy}), 68'(0));
      chk(rd_idx == 0 && wr_idx == 0, "R4/R5 no access",
          68'(rd_idx + wr_idx), 68'(0));
    end else begin
      chk(error == 1'b0, "R5 legal length no error", 68'(error), 68'(0));
      // offer a refused command while busy (R9)
      cmd_param = 64'h0;
      cmd_valid = 1'b1;
      for (int k = 0; k < 6; k++) @(negedge clk);
      cmd_valid = 1'b0;
      while (!done) begin
        chk(error == 1'b0, "R9 refused command raised error", 68'(error), 68'(0));
        @(negedge clk);
      end
      // R3 R8
      chk(wr_idx == len && rd_idx == len, "R3 access counts",
          68'(wr_idx), 68'(len));
      chk(busy == 1'b1, "R8 busy with done", 68'(busy), 68'(1));
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R8 done single cycle",
          68'({done, busy}), 68'(0));
      chk(wr_idx == len, "R3 no extra writes", 68'(wr_idx), 68'(len));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11
    chk({busy, done, error, rd_req_valid, wr_valid} == 5'b0 && cmd_ready,
        "R11 reset state", 68'({busy, done, error, rd_req_valid, wr_valid}),
        68'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cmd_ready == 1'b1 && busy == 1'b0, "R11 idle after reset",
        68'({cmd_ready, busy}), 68'(2'b10));
    // length sweep around lower bound
    for (int l = 0; l <= 9; l++)
      run_move(5'(l + 1), 16'(16'h0100 + l * 37), 5'(30 - l),
               16'(16'h4000 - l * 11), l);
    // wrap of both addresses, same device
    run_move(5'd7, 16'hFFFE, 5'd7, 16'hFFFC, 6);
    // upper bound with back-pressure (R10)
    stall_on = 1'b1;
    for (int l = 254; l <= 258; l++)
      run_move(5'd3, 16'(l * 5), 5'd19, 16'hFF80, l);
    run_move(5'd31, 16'h1234, 5'd0, 16'h8000, 12);
    run_move(5'd1, 16'h0, 5'd2, 16'h0, 511);
    run_move(5'd1, 16'h0, 5'd2, 16'h0, 300);
    stall_on = 1'b0;
    run_move(5'd9, 16'hFFFF, 5'd10, 16'h7FFF, 4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule